// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port on a simple synchronous register bus: address, write enable, write data, and a read data word that follows the address combinationally. Pin direction has no plain register. Software writes ones to a "make input" strobe register or a "make output" strobe register. Zero bits in either write leave their pins alone, so one pin can be turned around without disturbing the others.

Output values go through two half-port registers, one for pins 0–15 and one for pins 16–31. Each write word carries its own per-bit mask in bits 31:16 and the new values in bits 15:0. Only the masked pins change, so no read-modify-write is needed. The output latches keep their contents while a pin is an input. Driver software can therefore preload a value and then flip the pin to output with no glitch. Pin levels pass through a two-flop synchronizer before they can be read. The pads are modelled as an output-enable vector and an output-data vector.

Top module: `gpio_port`

## Requirements
- R1: Reset makes every pin an input (direction readback 0), clears every output latch to 0, and holds pad_oe and pad_out at 0.
- R2: A write to offset 0x04 makes each pin whose data bit is 1 an output. Pins whose bit is 0 keep their direction.
- R3: A write to offset 0x00 makes each pin whose data bit is 1 an input. Pins whose bit is 0 keep their direction.
- R4: A write to offset 0x0C updates the latches of pins 0–15. Bits 31:16 are the mask and bits 15:0 are the values. Latch bit i takes value bit i only when mask bit i+16 is 1.
- R5: A write to offset 0x10 does the same for pins 16–31: mask bit i+16 gates latch bit 16+i. The latches of pins 0–15 and the unmasked high pins are left unchanged.
- R6: pad_oe equals the direction state, with 1 meaning output. pad_out carries the latch value on output pins and 0 on input pins. A latch keeps its value while its pin is an input and drives it from the clock edge that turns the pin into an output.
- R7: Reading offset 0x08 returns pin_in as sampled two clock edges earlier, one bit per pin.
- R8: Reading offset 0x0C or 0x10 returns that half's 16 latch bits in bits 15:0, with zeros above. Reading offset 0x14 returns the direction vector.
- R9: Reads of offsets 0x00, 0x04 and every unmapped address return 0. Writes to offset 0x08, 0x14 or unmapped addresses change neither the directions nor the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Asynchronous pin levels |
| pad_oe | output | 32 | Per-pin output enable (1 = drive) |
| pad_out | output | 32 | Per-pin output data |

## Verification
A corrupted direction bit shows up on pad_oe on the edge after the write that caused it. A wrong latch bit hides while its pin is an input, but it appears on the 0x0C/0x10 readback right away and on pad_out once the pin is made an output. Because the reference model is compared every clock, a bad mask gate, a half-port that leaks into its neighbour, or a strobe that touches zero bits is reported within one cycle of the offending write. A synchronizer of the wrong depth shifts the 0x08 readback by a cycle, which the check made each cycle on pin changes catches.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int DATA_W      = 32;
    localparam int HALF_W      = DATA_W / 2;
    localparam int OFF_SET_IN  = 'h00;
    localparam int OFF_SET_OUT = 'h04;
    localparam int OFF_PIN_LVL = 'h08;
    localparam int OFF_OUT0    = 'h0C;
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] st_d [STAGES];
    logic [W-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (!rst_n) st_q[i] <= '0;
            else        st_q[i] <= st_d[i];
        end
    end

    assign dout = st_q[STAGES-1];
endmodule

// File: rtl/gpio_dir_ctrl.sv
module gpio_dir_ctrl #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mk_in_stb,
    input  logic         mk_out_stb,
    input  logic [W-1:0] sel_bits,
    output logic [W-1:0] dir
);
    typedef struct packed {
        logic [W-1:0] dir;
    } dir_state_t;

    dir_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mk_out_stb) st_d.dir = st_d.dir | sel_bits;
        if (mk_in_stb)  st_d.dir = st_d.dir & ~sel_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir = st_q.dir;
endmodule

// File: rtl/gpio_half_latch.sv
module gpio_half_latch #(
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [2*HW-1:0] wr_word,
    output logic [HW-1:0] q
);
    typedef struct packed {
        logic [HW-1:0] val;
    } half_state_t;

    half_state_t st_d, st_q;
    logic [HW-1:0] msk;
    logic [HW-1:0] nv;

    assign msk = wr_word[2*HW-1:HW];
    assign nv  = wr_word[HW-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_stb) st_d.val = (st_q.val & ~msk) | (nv & msk);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.val;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_out
);
    localparam int NHALF   = NPIN / HALF_W;
    localparam int OFF_DIR = OFF_OUT0 + 4 * NHALF;

    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] lat_q;
    logic [NPIN-1:0] lvl_q;
    logic            hit_in, hit_out;

    assign hit_in  = bus_we && (bus_addr == ADDR_W'(OFF_SET_IN));
    assign hit_out = bus_we && (bus_addr == ADDR_W'(OFF_SET_OUT));

    gpio_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (lvl_q)
    );

    gpio_dir_ctrl #(.W(NPIN)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .mk_in_stb  (hit_in),
        .mk_out_stb (hit_out),
        .sel_bits   (bus_wdata[NPIN-1:0]),
        .dir        (dir_q)
    );

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic hit_half;
        assign hit_half = bus_we && (bus_addr == ADDR_W'(OFF_OUT0 + 4 * h));
        gpio_half_latch #(.HW(HALF_W)) u_lat (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (hit_half),
            .wr_word (bus_wdata),
            .q       (lat_q[h*HALF_W +: HALF_W])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_PIN_LVL)) bus_rdata = DATA_W'(lvl_q);
        if (bus_addr == ADDR_W'(OFF_DIR))     bus_rdata = DATA_W'(dir_q);
        for (int h = 0; h < NHALF; h++) begin
            if (bus_addr == ADDR_W'(OFF_OUT0 + 4 * h))
                bus_rdata = DATA_W'(lat_q[h*HALF_W +: HALF_W]);
        end
    end

    assign pad_oe  = dir_q;
    assign pad_out = lat_q & dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int NPIN   = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPIN-1:0]   pin_in,
    input logic [NPIN-1:0]   pad_oe,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   lat
);
    localparam int NHALF   = NPIN / HALF_W;
    localparam int OFF_DIR = OFF_OUT0 + 4 * NHALF;

    logic [1:0] live_cnt;
    logic       mapped;

    always_ff @(posedge clk) begin
        if (!rst_n)                live_cnt <= '0;
        else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
    end

    always_comb begin
        mapped = (bus_addr == ADDR_W'(OFF_PIN_LVL)) || (bus_addr == ADDR_W'(OFF_DIR));
        for (int h = 0; h < NHALF; h++)
            if (bus_addr == ADDR_W'(OFF_OUT0 + 4 * h)) mapped = 1'b1;
    end

    // R2
    set_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_SET_OUT)) |=>
        ((pad_oe & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

    // R3
    set_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_SET_IN)) |=>
        ((pad_oe & $past(bus_wdata[NPIN-1:0])) == '0));

    // R4
    lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_OUT0)) |=>
        (lat[HALF_W-1:0] == (($past(lat[HALF_W-1:0]) & ~$past(bus_wdata[31:16]))
                             | ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16])))));

    // R5
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_OUT0 + 4)) |=>
        (lat[HALF_W-1:0] == $past(lat[HALF_W-1:0])));

    // R6
    idle_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pad_oe));

    // R7
    sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt >= 2'd2 && bus_addr == ADDR_W'(OFF_PIN_LVL)) |->
        (bus_rdata[NPIN-1:0] == $past(pin_in, 2)));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));
endmodule

bind gpio_port gpio_port_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .lat       (lat_q)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model state
    logic [31:0] m_dir = '0;
    logic [31:0] m_lat = '0;
    logic [31:0] m_s1 = '0;
    logic [31:0] m_s2 = '0;

    always #10 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h08:   return m_s2;
            8'h0C:   return {16'h0, m_lat[15:0]};
            8'h10:   return {16'h0, m_lat[31:16]};
            8'h14:   return m_dir;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '0; m_lat = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            m_s2 = m_s1;
            m_s1 = pin_in;
            if (bus_we) begin
                case (bus_addr)
                    8'h00: m_dir = m_dir & ~bus_wdata;
                    8'h04: m_dir = m_dir | bus_wdata;
                    8'h0C: for (int i = 0; i < 16; i++)
                               if (bus_wdata[16+i]) m_lat[i] = bus_wdata[i];
                    8'h10: for (int i = 0; i < 16; i++)
                               if (bus_wdata[16+i]) m_lat[16+i] = bus_wdata[i];
                    default: ;
                endcase
            end
        end
    end

    // compare every clock, half a period after the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("pad_oe (R2 R3)", pad_oe, m_dir);
            check("pad_out (R6)", pad_out, m_lat & m_dir);
            check("bus_rdata (R8)", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(input string t, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        tag = t; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); #2;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input string t, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk); #2;
        tag = t; bus_addr = a;
        #1 check($sformatf("read %h", a), bus_rdata, exp);
    endtask

    initial begin
        #4_000_000;
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state
        rd("R1", 8'h14, 32'h0);
        rd("R1", 8'h0C, 32'h0);
        rd("R1", 8'h10, 32'h0);
        check("pad_oe reset", pad_oe, 32'h0);
        check("pad_out reset", pad_out, 32'h0);
        // R4 R6: preload low latch while pins are inputs
        wr("R4", 8'h0C, 32'h00FF_00A5);
        rd("R6", 8'h0C, 32'h0000_00A5);
        check("pad_out held while input", pad_out, 32'h0);
        // R2: switch four pins to output, preloaded value drives
        wr("R2", 8'h04, 32'h0000_000F);
        check("pad_out after turn-on", pad_out, 32'h0000_0005);
        wr("R2", 8'h04, 32'h0);
        rd("R2", 8'h14, 32'h0000_000F);
        // R5: masked high writes
        wr("R5", 8'h10, 32'h0F0F_FFFF);
        rd("R5", 8'h10, 32'h0000_0F0F);
        rd("R5", 8'h0C, 32'h0000_00A5);
        wr("R5", 8'h10, 32'h0001_0000);
        rd("R5", 8'h10, 32'h0000_0F0E);
        rd("R5", 8'h0C, 32'h0000_00A5);
        // R4: full-mask low write
        wr("R4", 8'h0C, 32'hFFFF_1234);
        rd("R4", 8'h0C, 32'h0000_1234);
        // R3: make pins input
        wr("R3", 8'h04, 32'hFFFF_0000);
        wr("R3", 8'h00, 32'h0000_0003);
        rd("R3", 8'h14, 32'hFFFF_000C);
        wr("R3", 8'h00, 32'h0);
        rd("R3", 8'h14, 32'hFFFF_000C);
        check("pad_out mixed (R6)", pad_out, 32'h0F0E_0004);
        // R7: synchronizer latency
        @(negedge clk); #2;
        tag = "R7"; bus_addr = 8'h08; pin_in = 32'hDEAD_BEEF;
        @(negedge clk); #3;
        check("level after one edge", bus_rdata, 32'h0);
        @(negedge clk); #3;
        check("level after two edges", bus_rdata, 32'hDEAD_BEEF);
        pin_in = 32'h1357_9BDF;
        repeat (3) @(negedge clk);
        #3 check("level new pattern", bus_rdata, 32'h1357_9BDF);
        // R9: unmapped and write-only reads, ignored writes
        rd("R9", 8'h00, 32'h0);
        rd("R9", 8'h04, 32'h0);
        rd("R9", 8'h18, 32'h0);
        rd("R9", 8'h0E, 32'h0);
        wr("R9", 8'h08, 32'hFFFF_FFFF);
        wr("R9", 8'h14, 32'hFFFF_FFFF);
        wr("R9", 8'h18, 32'hFFFF_FFFF);
        rd("R9", 8'h14, 32'hFFFF_000C);
        rd("R9", 8'h0C, 32'h0000_1234);
        rd("R9", 8'h10, 32'h0000_0F0E);
        // R1: reset again clears everything
        @(negedge clk); #2 rst_n = 1'b0;
        @(negedge clk); #2 rst_n = 1'b1;
        rd("R1", 8'h14, 32'h0);
        rd("R1", 8'h10, 32'h0);
        check("pad_out after reset", pad_out, 32'h0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule